// File: doc/BRIEF.md
# Interrupting General-Purpose I/O Port

This block is a bank of general-purpose pins behind a small word-addressed register bus. Software drives pins through an output data register and a direction register. It can also change individual output bits through dedicated set and clear words, so no read-modify-write is needed. The pin values are brought into the clock domain through a synchronizer, and software reads them back from the input data word.

Every pin also feeds an interrupt detector. Three per-pin configuration bits choose among five trigger modes: edge or level, the polarity, and a both-edges override. Detected edges are held in sticky flags until software clears them by writing ones. Level triggers follow the live pin instead. An enable word gates what reaches the raw status, and a mask word removes pins from the masked status. A single interrupt line is the OR of the masked status bits.

The bus address is a word index, which is the byte offset divided by four. Reads return data one cycle after the read strobe.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register and every edge flag is zero, so `pin_out`, `pin_oe` and `irq` are all 0.
- R2: Word 0 (byte 0x00) writes the output data. Word 4 (0x10) ORs the written word into it. Word 5 (0x14) clears the written ones from it. Bits written as 0 to the set and clear words keep their value. `pin_out` equals the output data register.
- R3: Word 2 (0x08) holds the direction, where 1 means output. `pin_oe` equals this word, and it reads back.
- R4: Word 1 (0x04) returns the pin inputs after a two-flop synchronizer.
- R5: A pin with trigger-type bit 0 (word 13, 0x34), both-edge bit 0 (word 14, 0x38) and polarity bit 0 (word 15, 0x3C) latches its flag on a rising synchronized input.
- R6: With type 0, both-edge 0 and polarity 1, the flag latches on a falling input.
- R7: With type 0 and both-edge 1, either transition latches the flag, whatever the polarity.
- R8: With type 1 the status follows the live input: high when polarity is 0, low when polarity is 1. The status is not latched, and the interrupt clear word does not affect it.
- R9: A pin whose enable bit is 0 (word 8, 0x20) shows no raw status, and its edges are not latched.
- R10: Writing ones to word 12 (0x30) clears those pins' edge flags, and zero bits are left alone. An edge detected in the same cycle as its clear leaves the flag set.
- R11: Word 9 (0x24) returns the raw status. Word 10 (0x28) returns the raw status with the mask (word 11, 0x2C) removed. `irq` is the OR of the masked status.
- R12: Words 4, 5, 6, 7, 12, 16, 17 and every unlisted word read as zero. Writes to the read-only words 1, 9 and 10 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NPINS | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | NPINS | Read data, valid the cycle after `bus_rd` |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The embedded assertions check four things on every cycle. Set and clear writes change the output word exactly by OR and AND-NOT. An edge flag never drops without a clear bit. A qualified edge always leaves its flag set one cycle later, which includes the collision with a clear. Reserved words read zero. The trigger modes, polarity choices, enable and mask gating, and the synchronizer latency are shown only by the bench's scenarios. In those scenarios a behavioural model follows pin waveforms through each mode and compares the outputs and read data on every clock. One scenario times a rising edge to land in the same cycle as its clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int IDX_W = 5;
   typedef logic [IDX_W-1:0] widx_t;

   localparam widx_t W_DOUT   = 5'd0;
   localparam widx_t W_DIN    = 5'd1;
   localparam widx_t W_DIR    = 5'd2;
   localparam widx_t W_SET    = 5'd4;
   localparam widx_t W_CLR    = 5'd5;
   localparam widx_t W_RSV6   = 5'd6;
   localparam widx_t W_RSV7   = 5'd7;
   localparam widx_t W_IEN    = 5'd8;
   localparam widx_t W_RAW    = 5'd9;
   localparam widx_t W_MSKD   = 5'd10;
   localparam widx_t W_MASK   = 5'd11;
   localparam widx_t W_ICLR   = 5'd12;
   localparam widx_t W_TYPE   = 5'd13;
   localparam widx_t W_BOTH   = 5'd14;
   localparam widx_t W_POL    = 5'd15;
   localparam widx_t W_RSV16  = 5'd16;
   localparam widx_t W_RSV17  = 5'd17;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int NPINS  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] async_in,
   output logic [NPINS-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end

   logic [NPINS-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign sync_out = stg[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
   parameter int NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] smp,
   input  logic [NPINS-1:0] lvl_sel,
   input  logic [NPINS-1:0] any_edge,
   input  logic [NPINS-1:0] pol,
   input  logic [NPINS-1:0] en,
   input  logic [NPINS-1:0] clr,
   output logic [NPINS-1:0] raw
);

   logic [NPINS-1:0] prev_q;
   logic [NPINS-1:0] flag_q;
   logic [NPINS-1:0] hit;
   logic [NPINS-1:0] catch_v;

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      assign hit[p] = any_edge[p] ? (smp[p] ^ prev_q[p]) :
                      pol[p]      ? (prev_q[p] & ~smp[p]) :
                                    (smp[p] & ~prev_q[p]);
      assign raw[p] = en[p] & (lvl_sel[p] ? (smp[p] ^ pol[p]) : flag_q[p]);
   end

   assign catch_v = hit & en & ~lvl_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         flag_q <= '0;
      end else begin
         prev_q <= smp;
         flag_q <= (flag_q & ~clr) | catch_v;
      end
   end

   // R10: a flag only drops where a clear bit was written
   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_q) |=> (($past(flag_q) & ~flag_q & ~$past(clr)) == '0));

   // R5 / R10: a qualified edge is latched, even against a clear
   p_edge_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|catch_v) |=> ((flag_q & $past(catch_v)) == $past(catch_v)));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int NPINS       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [4:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [NPINS-1:0] bus_wdata,
   input  logic             bus_rd,
   output logic [NPINS-1:0] bus_rdata,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] pin_out,
   output logic [NPINS-1:0] pin_oe,
   output logic             irq
);

   if (NPINS < 1 || NPINS > 32) begin : g_bad_width
      $error("gpio_irq_port: NPINS must be 1..32");
   end

   logic [NPINS-1:0] dout_q, dir_q, ien_q, mask_q, type_q, both_q, pol_q;
   logic [NPINS-1:0] smp, raw, masked, clr_pulse, rd_mux, rdata_q;

   gpio_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_in),
      .sync_out (smp)
   );

   assign clr_pulse = (bus_wr && bus_addr == W_ICLR) ? bus_wdata : '0;

   gpio_trig_detect #(.NPINS(NPINS)) u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (smp),
      .lvl_sel  (type_q),
      .any_edge (both_q),
      .pol      (pol_q),
      .en       (ien_q),
      .clr      (clr_pulse),
      .raw      (raw)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '0;
         ien_q  <= '0;
         mask_q <= '0;
         type_q <= '0;
         both_q <= '0;
         pol_q  <= '0;
      end else if (bus_wr) begin
         case (bus_addr)
            W_DOUT:  dout_q <= bus_wdata;
            W_SET:   dout_q <= dout_q | bus_wdata;
            W_CLR:   dout_q <= dout_q & ~bus_wdata;
            W_DIR:   dir_q  <= bus_wdata;
            W_IEN:   ien_q  <= bus_wdata;
            W_MASK:  mask_q <= bus_wdata;
            W_TYPE:  type_q <= bus_wdata;
            W_BOTH:  both_q <= bus_wdata;
            W_POL:   pol_q  <= bus_wdata;
            default: ;
         endcase
      end
   end

   assign masked = raw & ~mask_q;

   always_comb begin
      case (bus_addr)
         W_DOUT:  rd_mux = dout_q;
         W_DIN:   rd_mux = smp;
         W_DIR:   rd_mux = dir_q;
         W_IEN:   rd_mux = ien_q;
         W_RAW:   rd_mux = raw;
         W_MSKD:  rd_mux = masked;
         W_MASK:  rd_mux = mask_q;
         W_TYPE:  rd_mux = type_q;
         W_BOTH:  rd_mux = both_q;
         W_POL:   rd_mux = pol_q;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;
   assign pin_out   = dout_q;
   assign pin_oe    = dir_q;
   assign irq       = |masked;

   // R2: set word ORs into the output data
   p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == W_SET) |=> (pin_out == $past(pin_out | bus_wdata)));

   // R2: clear word removes its ones from the output data
   p_clr_andn_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == W_CLR) |=> (pin_out == $past(pin_out & ~bus_wdata)));

   // R12: reserved words read as zero
   p_hole_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == W_SET || bus_addr == W_CLR || bus_addr == W_RSV6 ||
                  bus_addr == W_RSV7 || bus_addr == W_ICLR ||
                  bus_addr == W_RSV16 || bus_addr == W_RSV17))
      |=> (bus_rdata == '0));

endmodule

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_port #(.NPINS(32), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   // behavioural reference model
   logic [31:0] m_dout, m_dir, m_ien, m_mask, m_type, m_both, m_pol, m_flag, m_rdata;
   logic [31:0] hist[$];

   function automatic logic [31:0] m_raw(input logic [31:0] s);
      return m_ien & ((m_type & (s ^ m_pol)) | (~m_type & m_flag));
   endfunction

   function automatic logic [31:0] m_read(input logic [4:0] a, input logic [31:0] s);
      case (a)
         5'd0:    return m_dout;
         5'd1:    return s;
         5'd2:    return m_dir;
         5'd8:    return m_ien;
         5'd9:    return m_raw(s);
         5'd10:   return m_raw(s) & ~m_mask;
         5'd11:   return m_mask;
         5'd13:   return m_type;
         5'd14:   return m_both;
         5'd15:   return m_pol;
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin : model
      logic [31:0] cur, old, hit, clrv;
      if (!rst_n) begin
         {m_dout, m_dir, m_ien, m_mask, m_type, m_both, m_pol, m_flag, m_rdata} = '0;
         hist = {32'h0, 32'h0, 32'h0};
      end else begin
         old = hist[0];
         cur = hist[1];
         if (bus_rd) m_rdata = m_read(bus_addr, cur);
         for (int i = 0; i < 32; i++) begin
            if (m_both[i])     hit[i] = cur[i] != old[i];
            else if (m_pol[i]) hit[i] = old[i] && !cur[i];
            else               hit[i] = cur[i] && !old[i];
         end
         clrv = (bus_wr && bus_addr == 5'd12) ? bus_wdata : 32'h0;
         m_flag = (m_flag & ~clrv) | (hit & m_ien & ~m_type);
         if (bus_wr) begin
            case (bus_addr)
               5'd0:  m_dout = bus_wdata;
               5'd4:  m_dout = m_dout | bus_wdata;
               5'd5:  m_dout = m_dout & ~bus_wdata;
               5'd2:  m_dir  = bus_wdata;
               5'd8:  m_ien  = bus_wdata;
               5'd11: m_mask = bus_wdata;
               5'd13: m_type = bus_wdata;
               5'd14: m_both = bus_wdata;
               5'd15: m_pol  = bus_wdata;
               default: ;
            endcase
         end
         hist.push_back(pin_in);
         void'(hist.pop_front());
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 pin_out", pin_out, m_dout);
         chk("R3 pin_oe", pin_oe, m_dir);
         chk("R11 irq", {31'h0, irq}, {31'h0, |(m_raw(hist[1]) & ~m_mask)});
         chk("R12 rdata", bus_rdata, m_rdata);
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic summary;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin : main
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 pin_out", pin_out, 32'h0);
      chk("R1 pin_oe", pin_oe, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      rd(5'd9, v);  chk("R1 raw", v, 32'h0);
      rd(5'd15, v); chk("R1 pol", v, 32'h0);

      // R2 output data, set and clear words
      wr(5'd0, 32'h0000_00F0);
      wr(5'd4, 32'h0F00_0001);
      wr(5'd5, 32'h0000_0030);
      chk("R2 pin_out", pin_out, 32'h0F00_00C1);
      rd(5'd0, v); chk("R2 readback", v, 32'h0F00_00C1);

      // R3 direction
      wr(5'd2, 32'hFFFF_0000);
      chk("R3 pin_oe", pin_oe, 32'hFFFF_0000);
      rd(5'd2, v); chk("R3 readback", v, 32'hFFFF_0000);

      // R4 synchronized input
      pin_in = 32'hA5A5_0003;
      idle(3);
      rd(5'd1, v); chk("R4 input", v, 32'hA5A5_0003);
      pin_in = 32'h0;
      idle(4);

      // trigger configuration
      wr(5'd13, 32'h0000_0F00);
      wr(5'd15, 32'h0000_0A06);
      wr(5'd14, 32'h0000_0004);
      wr(5'd8,  32'h0000_0F07);
      rd(5'd9, v); chk("R8 active-low idle", v, 32'h0000_0A00);

      pin_in = 32'h0000_000F;
      idle(4);
      rd(5'd9, v); chk("R5 R7 R9 rising", v, 32'h0000_0A05);
      chk("R11 irq on", {31'h0, irq}, 32'h1);

      wr(5'd12, 32'h0000_0001);
      rd(5'd9, v); chk("R10 partial clear", v, 32'h0000_0A04);

      pin_in = 32'h0;
      idle(4);
      rd(5'd9, v); chk("R6 falling", v, 32'h0000_0A06);

      wr(5'd12, 32'hFFFF_FFFF);
      rd(5'd9, v); chk("R8 level kept", v, 32'h0000_0A00);

      pin_in = 32'h0000_0300;
      idle(4);
      rd(5'd9, v); chk("R8 level follow", v, 32'h0000_0900);

      // R11 masking
      wr(5'd11, 32'hFFFF_FFFF);
      chk("R11 irq masked", {31'h0, irq}, 32'h0);
      rd(5'd10, v); chk("R11 masked all", v, 32'h0);
      wr(5'd11, 32'h0000_0800);
      rd(5'd10, v); chk("R11 masked part", v, 32'h0000_0100);
      chk("R11 irq part", {31'h0, irq}, 32'h1);

      // R10 edge colliding with its own clear
      pin_in = 32'h0000_0301;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      wr(5'd12, 32'h0000_0001);
      rd(5'd9, v); chk("R10 set wins", v, 32'h0000_0901);

      // R12 reserved words and read-only writes
      foreach (v[i]) begin end
      for (int a = 4; a < 18; a++) begin
         if (a == 4 || a == 5 || a == 6 || a == 7 || a == 12 || a == 16 || a == 17) begin
            rd(5'(a), v); chk("R12 reserved zero", v, 32'h0);
         end
      end
      rd(5'd30, v); chk("R12 unlisted zero", v, 32'h0);
      wr(5'd9, 32'hFFFF_FFFF);
      wr(5'd1, 32'hFFFF_FFFF);
      rd(5'd9, v); chk("R12 raw unchanged", v, 32'h0000_0901);
      rd(5'd1, v); chk("R12 input unchanged", v, 32'h0000_0301);

      idle(2);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

endmodule